// File: doc/BRIEF.md
# USB Root Hub Port Status Bank

This block holds one 32-bit status and control word for each downstream port of a USB host controller root hub. A parameter sets the port count, from one to four. Software reads and writes the words through a simple register interface. Each word's low half-word shows the present state of its port: connection, enable, suspend, overcurrent, reset in progress, power and low-speed attachment. The upper half-word holds sticky change flags. Software clears each flag by writing 1 to it.

Each port reports connect, low-speed and overcurrent conditions on its own event inputs. A write of 1 to the reset bit starts a self-timed port reset of 10 ms. The duration comes from the clock frequency parameter. When the reset ends, the block enables the port and raises a completion flag.

A transaction-in-progress input guards every write. A write that arrives while a bus transaction is active is held for its port. It takes effect in the first cycle after the transaction ends. If a newer write arrives before then, it replaces the held one.

Top module: `rh_port_status_bank`

## Requirements
- R1: After reset every word reads 0. Bits 31:21 always read 0. A port index at or above NPORTS reads 0, and writes to it are ignored.
- R2: Bit 0 (connected) equals the port's conn_in value one clock after it is sampled. Any edge on conn_in sets bit 16 (connect change).
- R3: Writing 1 to any of bits 20:16 clears that change flag. Writing 0 leaves it unchanged. If an event sets the flag in the same cycle, the event wins.
- R4: Writing 1 to bit 4 while bit 0 is 1 starts a port reset. Bit 4 then reads 1 for CLK_KHZ*RST_MS clocks and then falls to 0. In that same cycle bit 20 (reset change) and bit 1 (enabled) become 1. When bit 0 is 0, the write has no effect.
- R5: A disconnect (falling conn_in) clears bit 1 and bit 2. It sets bit 17 (enable change) if the port was enabled. It stops a running reset without setting bit 20.
- R6: Bit 3 follows ovc_in. Bit 19 is set on a change of bit 3 only while ovc_per_port is 1.
- R7: Writing 1 to bit 1 enables a connected port. Writing 1 to bit 2 suspends an enabled port. Writing 1 to bit 8 turns port power on. Writing 0 to any of these bits has no effect.
- R8: Bit 9 (low-speed device) shows lowspd_in while conn_in is 1, and reads 0 otherwise.
- R9: A write that arrives while xfer_busy is 1 has no visible effect until xfer_busy is 0. It then applies at the next clock edge. Only the last write held for a port is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_port | input | 2 | Port index of the write |
| wr_data | input | 32 | Write data |
| rd_port | input | 2 | Port index of the read |
| rd_data | output | 32 | Word of the selected port |
| xfer_busy | input | 1 | Bus transaction in progress |
| ovc_per_port | input | 1 | Overcurrent is reported per port |
| conn_in | input | NPORTS | Device-attached level per port |
| lowspd_in | input | NPORTS | Low-speed device level per port |
| ovc_in | input | NPORTS | Overcurrent level per port |

## Verification
A reset timer stuck in its active state shows as bit 4 staying high past the exact reset length. Bit 20 and bit 1 then never rise, so a check placed one clock after the expected end catches it. A held write that is lost or applied too early shows as a power bit or change flag with the wrong value. The bench reads these one clock after xfer_busy falls, and also while xfer_busy is still high. A wrong connection state shows in bit 0 and bit 16 within one clock of a conn_in edge.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;

    localparam int B_CONN     = 0;
    localparam int B_ENAB     = 1;
    localparam int B_SUSP     = 2;
    localparam int B_OVI      = 3;
    localparam int B_RST      = 4;
    localparam int B_PWR      = 8;
    localparam int B_LOWSPD   = 9;
    localparam int B_CONN_CHG = 16;
    localparam int B_ENAB_CHG = 17;
    localparam int B_SUSP_CHG = 18;
    localparam int B_OVI_CHG  = 19;
    localparam int B_RST_CHG  = 20;

    typedef struct packed {
        logic lowspd;
        logic pwr;
        logic ovi;
        logic susp;
        logic enab;
        logic conn;
        logic rst_chg;
        logic ovi_chg;
        logic susp_chg;
        logic enab_chg;
        logic conn_chg;
    } port_state_t;

    function automatic logic [31:0] pack_word(port_state_t s, logic rst_act);
        logic [31:0] w;
        w             = '0;
        w[B_CONN]     = s.conn;
        w[B_ENAB]     = s.enab;
        w[B_SUSP]     = s.susp;
        w[B_OVI]      = s.ovi;
        w[B_RST]      = rst_act;
        w[B_PWR]      = s.pwr;
        w[B_LOWSPD]   = s.lowspd;
        w[B_CONN_CHG] = s.conn_chg;
        w[B_ENAB_CHG] = s.enab_chg;
        w[B_SUSP_CHG] = s.susp_chg;
        w[B_OVI_CHG]  = s.ovi_chg;
        w[B_RST_CHG]  = s.rst_chg;
        return w;
    endfunction

endpackage

// File: rtl/rh_reset_timer.sv
module rh_reset_timer #(
    parameter int CYC = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic abort,
    output logic active,
    output logic done
);
    localparam int CW = $clog2(CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic [CW-1:0] cnt;

    assign done = active && (cnt == LAST) && !abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (abort) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (start && !active) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (active) begin
            if (cnt == LAST) active <= 1'b0;
            else             cnt    <= cnt + 1'b1;
        end
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt <= LAST));                                  // R4
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst)
        done |=> !active);                                          // R4
endmodule

// File: rtl/rh_write_hold.sv
module rh_write_hold (
    input  logic        clk,
    input  logic        rst,
    input  logic        busy,
    input  logic        wr_hit,
    input  logic [31:0] wr_data,
    output logic        apply,
    output logic [31:0] apply_data
);
    logic        pend_v;
    logic [31:0] pend_d;

    assign apply      = !busy && (wr_hit || pend_v);
    assign apply_data = busy ? '0 :
                        ((pend_v ? pend_d : '0) | (wr_hit ? wr_data : '0));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend_d <= '0;
        end else if (busy) begin
            if (wr_hit) begin
                pend_v <= 1'b1;
                pend_d <= wr_data;
            end
        end else begin
            pend_v <= 1'b0;
        end
    end

    AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |-> !apply);                                           // R9
    AST_PEND_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (pend_v && !busy) |-> apply);                               // R9
    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !pend_v);                                         // R9
endmodule

// File: rtl/rh_port_slice.sv
module rh_port_slice
    import rh_port_pkg::*;
#(
    parameter int RST_CYC = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        conn_in,
    input  logic        lowspd_in,
    input  logic        ovc_in,
    input  logic        ovc_per_port,
    input  logic        apply,
    input  logic [31:0] apply_data,
    output logic [31:0] word
);
    port_state_t st, nx;
    logic rst_act, rst_done, rst_start, conn_edge, unplug;

    assign conn_edge = conn_in ^ st.conn;
    assign unplug    = st.conn & ~conn_in;
    assign rst_start = apply & apply_data[B_RST] & st.conn & ~rst_act;

    rh_reset_timer #(.CYC(RST_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (rst_start),
        .abort  (unplug),
        .active (rst_act),
        .done   (rst_done)
    );

    always_comb begin
        nx        = st;
        nx.conn   = conn_in;
        nx.lowspd = conn_in & lowspd_in;
        nx.ovi    = ovc_in;
        if (apply) begin
            if (apply_data[B_CONN_CHG]) nx.conn_chg = 1'b0;
            if (apply_data[B_ENAB_CHG]) nx.enab_chg = 1'b0;
            if (apply_data[B_SUSP_CHG]) nx.susp_chg = 1'b0;
            if (apply_data[B_OVI_CHG])  nx.ovi_chg  = 1'b0;
            if (apply_data[B_RST_CHG])  nx.rst_chg  = 1'b0;
            if (apply_data[B_ENAB] && st.conn) nx.enab = 1'b1;
            if (apply_data[B_SUSP] && st.enab) nx.susp = 1'b1;
            if (apply_data[B_PWR])             nx.pwr  = 1'b1;
        end
        if (rst_done) begin
            nx.enab    = 1'b1;
            nx.rst_chg = 1'b1;
        end
        if (conn_edge) nx.conn_chg = 1'b1;
        if (unplug) begin
            nx.enab = 1'b0;
            nx.susp = 1'b0;
            if (st.enab) nx.enab_chg = 1'b1;
        end
        if (ovc_per_port && (ovc_in != st.ovi)) nx.ovi_chg = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= nx;
    end

    assign word = pack_word(st, rst_act);

    AST_CONN_EDGE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (conn_in != st.conn) |=> st.conn_chg);                      // R2
    AST_RST_END_FLAGS: assert property (@(posedge clk) disable iff (rst)
        rst_done |=> (st.rst_chg && st.enab && !rst_act));          // R4
    AST_CHG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (st.conn_chg && !apply) |=> st.conn_chg);                   // R3
    AST_UNPLUG_DISABLES: assert property (@(posedge clk) disable iff (rst)
        unplug |=> (!st.enab && !rst_act && !st.susp));             // R5
endmodule

// File: rtl/rh_port_status_bank.sv
module rh_port_status_bank
    import rh_port_pkg::*;
#(
    parameter int NPORTS  = 4,
    parameter int CLK_KHZ = 100000,
    parameter int RST_MS  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_port,
    input  logic [31:0]       wr_data,
    input  logic [1:0]        rd_port,
    output logic [31:0]       rd_data,
    input  logic              xfer_busy,
    input  logic              ovc_per_port,
    input  logic [NPORTS-1:0] conn_in,
    input  logic [NPORTS-1:0] lowspd_in,
    input  logic [NPORTS-1:0] ovc_in
);
    localparam int RST_CYC = CLK_KHZ * RST_MS;

    logic [31:0] words [NPORTS];

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        logic        hit, apply;
        logic [31:0] adata;

        assign hit = wr_en && (wr_port == 2'(i));

        rh_write_hold u_hold (
            .clk        (clk),
            .rst        (rst),
            .busy       (xfer_busy),
            .wr_hit     (hit),
            .wr_data    (wr_data),
            .apply      (apply),
            .apply_data (adata)
        );

        rh_port_slice #(.RST_CYC(RST_CYC)) u_slice (
            .clk          (clk),
            .rst          (rst),
            .conn_in      (conn_in[i]),
            .lowspd_in    (lowspd_in[i]),
            .ovc_in       (ovc_in[i]),
            .ovc_per_port (ovc_per_port),
            .apply        (apply),
            .apply_data   (adata),
            .word         (words[i])
        );
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NPORTS; i++)
            if (rd_port == 2'(i)) rd_data = words[i];
    end

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        rd_data[31:21] == '0);                                      // R1
endmodule

// File: tb/sim_rh_port_status_bank.sv
module sim_rh_port_status_bank;
    localparam int NP  = 3;
    localparam int KHZ = 2;
    localparam int MS  = 10;
    localparam int CYC = KHZ * MS;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_port = '0;
    logic [31:0]   wr_data = '0;
    logic [1:0]    rd_port = '0;
    logic [31:0]   rd_data;
    logic          xfer_busy = 1'b0;
    logic          ovc_per_port = 1'b0;
    logic [NP-1:0] conn_in = '0;
    logic [NP-1:0] lowspd_in = '0;
    logic [NP-1:0] ovc_in = '0;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    rh_port_status_bank #(.NPORTS(NP), .CLK_KHZ(KHZ), .RST_MS(MS)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
        .rd_port(rd_port), .rd_data(rd_data), .xfer_busy(xfer_busy),
        .ovc_per_port(ovc_per_port), .conn_in(conn_in), .lowspd_in(lowspd_in),
        .ovc_in(ovc_in)
    );

    function automatic logic [31:0] bitval(int pos, logic v);
        return {31'b0, v} << pos;
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] p, logic [31:0] d);
        wr_en   = 1'b1;
        wr_port = p;
        wr_data = d;
        step(1);
        wr_en   = 1'b0;
    endtask

    task automatic chk(string req, logic [1:0] p, logic [31:0] mask, logic [31:0] exp);
        rd_port = p;
        #1;
        checks++;
        if ((rd_data & mask) !== (exp & mask)) begin
            errors++;
            $display("FAIL %s port %0d: actual %h expected %h (mask %h)",
                     req, p, rd_data & mask, exp & mask, mask);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        step(3);
        rst = 1'b0;
        step(1);
        // R1 reset state and unimplemented port
        for (int p = 0; p < 4; p++) chk("R1", 2'(p), 32'hFFFF_FFFF, 32'h0);

        // R2 connect tracking
        conn_in[0] = 1'b1;
        step(1);
        chk("R2", 0, 32'h0001_0001, 32'h0001_0001);

        // R3 write 0 no effect, write 1 clears
        wr(0, 32'h0);
        chk("R3", 0, 32'h0001_0000, 32'h0001_0000);
        wr(0, 32'h0001_0000);
        chk("R3", 0, 32'h0001_0000, 32'h0);

        // R4 reset on a disconnected port is ignored
        wr(2, bitval(4, 1'b1));
        chk("R4", 2, 32'h0010_0012, 32'h0);

        // R4 timed reset
        wr(0, bitval(4, 1'b1));
        step(CYC - 1);
        chk("R4", 0, 32'h0010_0012, 32'h0000_0010);
        step(1);
        chk("R4", 0, 32'h0010_0012, 32'h0010_0002);

        // R7 suspend and power set
        wr(0, bitval(2, 1'b1));
        chk("R7", 0, 32'h0000_0004, 32'h0000_0004);
        wr(0, bitval(8, 1'b1));
        chk("R7", 0, 32'h0000_0100, 32'h0000_0100);
        wr(0, 32'h0);
        chk("R7", 0, 32'h0000_0106, 32'h0000_0106);

        // R5 disconnect of enabled port
        conn_in[0] = 1'b0;
        step(1);
        chk("R5", 0, 32'h0003_0007, 32'h0003_0000);

        // R8 low speed
        conn_in[1] = 1'b1;
        lowspd_in[1] = 1'b1;
        step(1);
        chk("R8", 1, 32'h0000_0201, 32'h0000_0201);

        // R5 reset aborted by disconnect
        wr(1, bitval(4, 1'b1));
        step(5);
        chk("R4", 1, 32'h0000_0010, 32'h0000_0010);
        conn_in[1] = 1'b0;
        step(1);
        chk("R5", 1, 32'h0010_0212, 32'h0);
        step(CYC);
        chk("R5", 1, 32'h0010_0012, 32'h0);

        // R6 overcurrent
        ovc_in[2] = 1'b1;
        step(1);
        chk("R6", 2, 32'h0008_0008, 32'h0000_0008);
        ovc_per_port = 1'b1;
        ovc_in[2] = 1'b0;
        step(1);
        chk("R6", 2, 32'h0008_0008, 32'h0008_0000);

        // R1 reserved bits and unimplemented port
        wr(2, 32'hFFE0_0000);
        chk("R1", 2, 32'hFFE0_0000, 32'h0);
        wr(3, 32'hFFFF_FFFF);
        chk("R1", 3, 32'hFFFF_FFFF, 32'h0);

        // R9 deferral
        xfer_busy = 1'b1;
        wr(2, bitval(8, 1'b1));
        chk("R9", 2, 32'h0000_0100, 32'h0);
        step(3);
        chk("R9", 2, 32'h0000_0100, 32'h0);
        xfer_busy = 1'b0;
        step(1);
        chk("R9", 2, 32'h0000_0100, 32'h0000_0100);

        // R9 latest held write replaces earlier one
        xfer_busy = 1'b1;
        wr(1, bitval(8, 1'b1));
        wr(1, 32'h0001_0000);
        chk("R9", 1, 32'h0001_0100, 32'h0001_0000);
        xfer_busy = 1'b0;
        step(1);
        chk("R9", 1, 32'h0001_0100, 32'h0);

        // R2 R3 R9 random: toggle connect, clear flags with or without busy
        for (int it = 0; it < 30; it++) begin
            int  p;
            bit  busy;
            p = int'($urandom % NP);
            busy = 1'($urandom % 2);
            conn_in[p] = ~conn_in[p];
            step(1);
            chk("R2", 2'(p), 32'h0001_0001, bitval(16, 1'b1) | bitval(0, conn_in[p]));
            xfer_busy = busy;
            wr(2'(p), 32'h001F_0000);
            chk("R9", 2'(p), 32'h0001_0000, bitval(16, busy));
            xfer_busy = 1'b0;
            step(1);
            chk("R3", 2'(p), 32'h0001_0001, bitval(0, conn_in[p]));
        end

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule